// File: doc/BRIEF.md
# Framed I/Q Sample Deframer

This block sits behind a narrow source-synchronous receive port. Each interface clock brings one 6-bit word and a frame strobe. The block rebuilds 12-bit in-phase/quadrature samples from those words. Each sample arrives as four words: the upper six bits of I, then the upper six bits of Q, then the lower six bits of I, then the lower six bits of Q. Two such groups, one per channel slot, make an 8-word cycle.

The frame strobe lets the block find word 0 of a group. The block then locks its word counter to that position, raises an aligned flag, and presents two I/Q pairs with a one-cycle valid strobe. A frame-per-sample input selects between two strobe conventions. A dual-channel input selects whether the second slot carries a second channel or is to be discarded or duplicated. Build-time masks can invert any data bit and the frame strobe before decoding.

Top module: `iq_deframer`

## Requirements
- R1: The word sampled at group position 0 supplies I[11:6], position 1 supplies Q[11:6], position 2 supplies I[5:0] and position 3 supplies Q[5:0].
- R2: With dual_i high, the group in slot 0 drives i0_o/q0_o and the group in slot 1 drives i1_o/q1_o. All four update together at the clock edge that samples the last word of slot 1.
- R3: With frame_per_sample_i low, the strobe is high for words 0 and 1 of slot 0 only, so a group start recurs every 8 words. With it high, the strobe is high for words 0 and 1 of both slots, so a group start recurs every 4 words.
- R4: With dual_i low and frame_per_sample_i low, the four words of slot 1 never reach an output. The slot-0 sample is written to both output pairs once per 8 words.
- R5: With dual_i low and frame_per_sample_i high, every completed group is written to both output pairs, once per 4 words.
- R6: A low-to-high step of the conditioned strobe marks word 0 of a group. The first such step after reset fixes the position. aligned_o rises at the clock edge that samples the second further step arriving exactly on the expected group boundary.
- R7: After lock, a rising step at any other position clears aligned_o at that edge and restarts the count with that word as word 0. The block then needs two further on-boundary steps to realign.
- R8: valid_o is high for exactly one cycle after each output update, and only while aligned_o was already high when the completing word was sampled.
- R9: Between valid pulses all four sample outputs hold their values.
- R10: While rst_ni is low, aligned_o, valid_o and all sample outputs are zero. After release, alignment is reacquired as in R6.
- R11: Parameter DATA_INV is XORed onto data_i bit by bit, and FRAME_INV onto frame_i, before any decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface word clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dual_i | input | 1 | High: two channels; low: single channel |
| frame_per_sample_i | input | 1 | High: strobe marks every group; low: slot 0 only |
| data_i | input | WORD_W | Received data word |
| frame_i | input | 1 | Received frame strobe |
| aligned_o | output | 1 | Word alignment locked |
| valid_o | output | 1 | One-cycle pulse on a new sample set |
| i0_o | output | 2*WORD_W | Channel 0 in-phase sample |
| q0_o | output | 2*WORD_W | Channel 0 quadrature sample |
| i1_o | output | 2*WORD_W | Channel 1 in-phase sample |
| q1_o | output | 2*WORD_W | Channel 1 quadrature sample |

## Verification
All four combinations of the mode and framing inputs are swept with clean streams. Each stream uses sample values that differ per channel, per I/Q and per cycle, so a swapped half-word, a swapped channel or a stale pair shows up as a value mismatch. In single-channel slot-discard mode, slot 1 carries distinct junk words; leakage shows up as a corrupted duplicate. A one-word slip is inserted after lock in every mode to separate correct resynchronisation and lock counting from a sticky aligned flag. A second instance with inverted data and strobe, fed pre-inverted stimulus, must match the first exactly.

// File: rtl/iq_deframer_pkg.sv
package iq_deframer_pkg;

  localparam int unsigned GROUP_WORDS = 4;
  localparam int unsigned CYCLE_WORDS = 2 * GROUP_WORDS;
  localparam int unsigned ROLE_W      = $clog2(GROUP_WORDS);
  localparam int unsigned POS_W       = $clog2(CYCLE_WORDS);

  typedef enum logic [ROLE_W-1:0] {
    W_IHI = 2'd0,
    W_QHI = 2'd1,
    W_ILO = 2'd2,
    W_QLO = 2'd3
  } word_role_e;

endpackage

// File: rtl/iq_deframer_sync.sv
module iq_deframer_sync
  import iq_deframer_pkg::*;
#(
  parameter int unsigned LOCK_HITS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             fps_i,
  output logic [POS_W-1:0] pos_o,
  output logic             aligned_o
);

  localparam int unsigned HIT_W = $clog2(LOCK_HITS + 1);

  logic             frame_q;
  logic             synced_q;
  logic             aligned_q;
  logic [POS_W-1:0] cnt_q;
  logic [HIT_W-1:0] hits_q;
  logic             rise;
  logic             on_grid;
  logic             resync;

  always_comb begin
    rise    = frame_i & ~frame_q;
    on_grid = fps_i ? (cnt_q[ROLE_W-1:0] == '0) : (cnt_q == '0);
    resync  = rise & (~synced_q | ~on_grid);
    pos_o   = resync ? '0 : cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q   <= 1'b0;
      synced_q  <= 1'b0;
      aligned_q <= 1'b0;
      cnt_q     <= '0;
      hits_q    <= '0;
    end else begin
      frame_q <= frame_i;
      cnt_q   <= pos_o + 1'b1;
      if (rise) begin
        if (resync) begin
          synced_q  <= 1'b1;
          hits_q    <= '0;
          aligned_q <= 1'b0;
        end else begin
          if (hits_q != HIT_W'(LOCK_HITS)) hits_q <= hits_q + 1'b1;
          if (hits_q >= HIT_W'(LOCK_HITS - 1)) aligned_q <= 1'b1;
        end
      end
    end
  end

  assign aligned_o = aligned_q;

endmodule

// File: rtl/iq_deframer_asm.sv
module iq_deframer_asm
  import iq_deframer_pkg::*;
#(
  parameter int unsigned WORD_W = 6,
  localparam int unsigned SMP_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic              done_o,
  output logic              slot_o,
  output logic [SMP_W-1:0]  smp_i_o,
  output logic [SMP_W-1:0]  smp_q_o
);

  word_role_e        role;
  logic [WORD_W-1:0] i_hi_q;
  logic [WORD_W-1:0] q_hi_q;
  logic [WORD_W-1:0] i_lo_q;

  assign role = word_role_e'(pos_i[ROLE_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_hi_q <= '0;
      q_hi_q <= '0;
      i_lo_q <= '0;
    end else begin
      case (role)
        W_IHI:   i_hi_q <= word_i;
        W_QHI:   q_hi_q <= word_i;
        W_ILO:   i_lo_q <= word_i;
        default: ;
      endcase
    end
  end

  // Last word of a group completes Q combinationally.
  assign done_o  = (role == W_QLO);
  assign slot_o  = pos_i[POS_W-1];
  assign smp_i_o = {i_hi_q, i_lo_q};
  assign smp_q_o = {q_hi_q, word_i};

endmodule

// File: rtl/iq_deframer_steer.sv
module iq_deframer_steer #(
  parameter int unsigned SMP_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dual_i,
  input  logic             fps_i,
  input  logic             aligned_i,
  input  logic             done_i,
  input  logic             slot_i,
  input  logic [SMP_W-1:0] smp_i_i,
  input  logic [SMP_W-1:0] smp_q_i,
  output logic             valid_o,
  output logic [SMP_W-1:0] i0_o,
  output logic [SMP_W-1:0] q0_o,
  output logic [SMP_W-1:0] i1_o,
  output logic [SMP_W-1:0] q1_o
);

  logic [SMP_W-1:0] stage_i_q;
  logic [SMP_W-1:0] stage_q_q;
  logic             commit_dual;
  logic             commit_single;

  always_comb begin
    commit_dual   = aligned_i & done_i & dual_i & slot_i;
    commit_single = aligned_i & done_i & ~dual_i & (fps_i | ~slot_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_i_q <= '0;
      stage_q_q <= '0;
      valid_o   <= 1'b0;
      i0_o      <= '0;
      q0_o      <= '0;
      i1_o      <= '0;
      q1_o      <= '0;
    end else begin
      valid_o <= commit_dual | commit_single;
      if (done_i && !slot_i) begin
        stage_i_q <= smp_i_i;
        stage_q_q <= smp_q_i;
      end
      if (commit_dual) begin
        i0_o <= stage_i_q;
        q0_o <= stage_q_q;
        i1_o <= smp_i_i;
        q1_o <= smp_q_i;
      end else if (commit_single) begin
        i0_o <= smp_i_i;
        q0_o <= smp_q_i;
        i1_o <= smp_i_i;
        q1_o <= smp_q_i;
      end
    end
  end

endmodule

// File: rtl/iq_deframer.sv
module iq_deframer
  import iq_deframer_pkg::*;
#(
  parameter int unsigned          WORD_W    = 6,
  parameter logic [WORD_W-1:0]    DATA_INV  = '0,
  parameter logic                 FRAME_INV = 1'b0,
  parameter int unsigned          LOCK_HITS = 2,
  localparam int unsigned         SMP_W     = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dual_i,
  input  logic              frame_per_sample_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              frame_i,
  output logic              aligned_o,
  output logic              valid_o,
  output logic [SMP_W-1:0]  i0_o,
  output logic [SMP_W-1:0]  q0_o,
  output logic [SMP_W-1:0]  i1_o,
  output logic [SMP_W-1:0]  q1_o
);

  logic [WORD_W-1:0] data_c;
  logic              frame_c;
  logic [POS_W-1:0]  pos;
  logic              done;
  logic              slot;
  logic [SMP_W-1:0]  smp_i;
  logic [SMP_W-1:0]  smp_q;

  for (genvar b = 0; b < WORD_W; b++) begin : g_inv
    assign data_c[b] = data_i[b] ^ DATA_INV[b];
  end
  assign frame_c = frame_i ^ FRAME_INV;

  iq_deframer_sync #(
    .LOCK_HITS (LOCK_HITS)
  ) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_i   (frame_c),
    .fps_i     (frame_per_sample_i),
    .pos_o     (pos),
    .aligned_o (aligned_o)
  );

  iq_deframer_asm #(
    .WORD_W (WORD_W)
  ) u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .word_i  (data_c),
    .pos_i   (pos),
    .done_o  (done),
    .slot_o  (slot),
    .smp_i_o (smp_i),
    .smp_q_o (smp_q)
  );

  iq_deframer_steer #(
    .SMP_W (SMP_W)
  ) u_steer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dual_i    (dual_i),
    .fps_i     (frame_per_sample_i),
    .aligned_i (aligned_o),
    .done_i    (done),
    .slot_i    (slot),
    .smp_i_i   (smp_i),
    .smp_q_i   (smp_q),
    .valid_o   (valid_o),
    .i0_o      (i0_o),
    .q0_o      (q0_o),
    .i1_o      (i1_o),
    .q1_o      (q1_o)
  );

endmodule

// File: rtl/iq_deframer_chk.sv
module iq_deframer_chk #(
  parameter int unsigned SMP_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dual_i,
  input logic             aligned_o,
  input logic             valid_o,
  input logic [SMP_W-1:0] i0_o,
  input logic [SMP_W-1:0] q0_o,
  input logic [SMP_W-1:0] i1_o,
  input logic [SMP_W-1:0] q1_o
);

  // R8: a set is only released once lock was already held
  p_valid_needs_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(aligned_o));

  // R8: single-cycle pulse
  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R9: outputs move only together with a valid pulse
  p_hold_outputs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(i0_o) || !$stable(q0_o) || !$stable(i1_o) || !$stable(q1_o)) |-> valid_o);

  // R4, R5: single-channel sets are duplicated on both pairs
  p_single_dup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(dual_i)) |-> (i1_o == i0_o && q1_o == q0_o));

  // R10: everything cleared while reset is held
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r10: assert (!aligned_o && !valid_o && i0_o == '0 && q0_o == '0
                                 && i1_o == '0 && q1_o == '0);
    end
  end

endmodule

bind iq_deframer iq_deframer_chk #(
  .SMP_W (SMP_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dual_i    (dual_i),
  .aligned_o (aligned_o),
  .valid_o   (valid_o),
  .i0_o      (i0_o),
  .q0_o      (q0_o),
  .i1_o      (i1_o),
  .q1_o      (q1_o)
);

// File: tb/iq_deframer_bench.sv
`timescale 1ns/1ps
module iq_deframer_bench;

  localparam logic [5:0] INV_D = 6'h2D;
  localparam logic       INV_F = 1'b1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       dual  = 1'b1;
  logic       fps   = 1'b0;
  logic [5:0] data  = '0;
  logic       frame = 1'b0;

  logic        a_al, a_v, b_al, b_v;
  logic [11:0] a_i0, a_q0, a_i1, a_q1, b_i0, b_q0, b_i1, b_q1;

  iq_deframer u_iq_deframer (
    .clk_i (clk), .rst_ni (rst_n), .dual_i (dual), .frame_per_sample_i (fps),
    .data_i (data), .frame_i (frame), .aligned_o (a_al), .valid_o (a_v),
    .i0_o (a_i0), .q0_o (a_q0), .i1_o (a_i1), .q1_o (a_q1));

  iq_deframer #(.DATA_INV (INV_D), .FRAME_INV (INV_F)) u_iq_deframer_inv (
    .clk_i (clk), .rst_ni (rst_n), .dual_i (dual), .frame_per_sample_i (fps),
    .data_i (data ^ INV_D), .frame_i (frame ^ INV_F), .aligned_o (b_al), .valid_o (b_v),
    .i0_o (b_i0), .q0_o (b_q0), .i1_o (b_i1), .q1_o (b_q1));

  int n_chk = 0, n_bad = 0, rises = 0;
  bit slip = 0, finished = 0;
  logic [11:0] e_i0 = '0, e_q0 = '0, e_i1 = '0, e_q1 = '0;

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_all(string req, bit al, bit v);
    chk("R6", "aligned", 32'(a_al), 32'(al));
    chk("R8", "valid", 32'(a_v), 32'(v));
    chk(req, "i0", 32'(a_i0), 32'(e_i0));
    chk(req, "q0", 32'(a_q0), 32'(e_q0));
    chk(req, "i1", 32'(a_i1), 32'(e_i1));
    chk(req, "q1", 32'(a_q1), 32'(e_q1));
    // R11: inverted instance must match exactly
    chk("R11", "inv aligned/valid", {30'd0, b_al, b_v}, {30'd0, al, v});
    chk("R11", "inv pair0", {8'd0, b_i0, b_q0}, {8'd0, e_i0, e_q0});
    chk("R11", "inv pair1", {8'd0, b_i1, b_q1}, {8'd0, e_i1, e_q1});
  endtask

  task automatic push(logic [5:0] w, logic f);
    @(negedge clk);
    data  = w;
    frame = f;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] smp(int cyc, int idx);
    return 12'((cyc * 613 + idx * 1171 + 5) % 4096);
  endfunction

  task automatic run_cycle(int cyc);
    logic [11:0] s [4];
    for (int k = 0; k < 4; k++) s[k] = smp(cyc, k);
    for (int w = 0; w < 8; w++) begin
      int ch = w / 4;
      int r  = w % 4;
      logic [11:0] si = s[2*ch];
      logic [11:0] sq = s[2*ch+1];
      logic [5:0]  word;
      logic        f;
      bit          commit, al, v;
      string       req;
      // R1: word order I hi, Q hi, I lo, Q lo
      case (r)
        0: word = si[11:6];
        1: word = sq[11:6];
        2: word = si[5:0];
        default: word = sq[5:0];
      endcase
      if (!dual && !fps && ch == 1) word = 6'((cyc * 29 + w * 11 + 7) % 64);  // R4 junk
      f = (r < 2) && (fps || ch == 0);  // R3
      push(word, f);
      if (f && r == 0) begin
        if (slip) begin rises = 1; slip = 0; end  // R7 resync
        else rises++;
      end
      al = (rises >= 3);
      commit = (r == 3) && (dual ? (ch == 1) : (fps || ch == 0));
      v = al && commit;
      req = "R9";
      if (v) begin
        if (dual) begin
          e_i0 = s[0]; e_q0 = s[1]; e_i1 = s[2]; e_q1 = s[3]; req = "R2";
        end else begin
          e_i0 = si; e_q0 = sq; e_i1 = si; e_q1 = sq;
          req = fps ? "R5" : "R4";
        end
      end
      check_all(req, al, v);
    end
  endtask

  task automatic do_reset(bit d, bit p);
    @(negedge clk);
    rst_n = 1'b0;
    frame = 1'b0;
    data  = '0;
    dual  = d;
    fps   = p;
    repeat (2) @(posedge clk);
    #1;
    e_i0 = '0; e_q0 = '0; e_i1 = '0; e_q1 = '0;
    rises = 0;
    slip = 0;
    check_all("R10", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int m = 0; m < 4; m++) begin
      do_reset(m[1], m[0]);
      for (int c = 0; c < 10; c++) run_cycle(m * 100 + c);
      // R7: one-word slip after lock
      push(6'h15, 1'b0);
      check_all("R7", rises >= 3, 1'b0);
      slip = 1;
      for (int c = 10; c < 16; c++) run_cycle(m * 100 + c);
    end
    // R10: reset mid-stream, then reacquire
    run_cycle(900);
    do_reset(1'b1, 1'b0);
    for (int c = 0; c < 5; c++) run_cycle(950 + c);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule